// File: doc/BRIEF.md
# Vector Length Setting Unit

This block executes the length-setting part of a vector instruction. A 12-bit length-type field arrives with a valid strobe. The unit decodes it, loads a new maximum vector length (MVL) from a small immediate, and derives the current vector length (VL). VL either equals MVL or is the smaller of MVL and the value in a source register. The field can also ask for the resulting VL to be written back to a destination register. When the field names a source register, the unit reads it through a combinational register read port in the same cycle. Write-back leaves through a registered write port one cycle later, at the same edge that updates VL and MVL.

Bit 11 of the field selects between two modes. Mode 0 uses two 3-bit compact register numbers. Mode 1 uses one full 5-bit register number plus a direction bit. One mode-1 encoding is reserved and raises an illegal flag. A separate control-register write port loads VL directly; a written value of zero stands for the largest supported length. The set-length path can produce VL = 0, so that a following branch can skip a loop body entirely.

Top module: `vl_set_unit`

## Requirements
- R1: After reset, VL and MVL both read 64. The write strobe and the illegal flag are low.
- R2: A valid field of all zeros leaves VL and MVL unchanged. It writes no register and raises no illegal flag.
- R3: When bit 11 is 0, bits 10:6 hold imm and the new MVL is imm+1 (1..32). Bits 2:0 give a compact source number and bits 5:3 a compact destination number. A nonzero compact number c names register 8+c, and a nonzero source drives that address on the read port, with read enable, in the same cycle as the valid strobe.
- R4: In mode 0, VL becomes min(register value, new MVL) when the compact source is nonzero, compared over the full register width. A register value of 0 yields VL = 0. With a zero source number, VL becomes the new MVL.
- R5: In mode 0 with a nonzero compact destination, the new VL, zero-extended, is written to register 8+destination in the cycle after the strobe. With a zero destination number, no write occurs.
- R6: When bit 11 is 1 and bit 5 is 0, MVL becomes imm+1 and VL becomes MVL. If bits 4:0 are nonzero, VL is written to that register in the next cycle.
- R7: When bit 11 is 1, bit 5 is 1 and bits 4:0 are nonzero, the unit reads register bits 4:0. MVL becomes imm+1 and VL becomes min(register, MVL). No register is written.
- R8: The encoding with bit 11 = 1, bit 5 = 1 and bits 4:0 zero raises the illegal flag for exactly the one cycle after the strobe. It changes neither VL nor MVL and writes nothing.
- R9: A control-register write sets VL to the 6-bit written value, with zero taken as 64. MVL is left unchanged.
- R10: When a valid field and a control-register write arrive in the same cycle, the field alone takes effect.
- R11: VL, MVL, the write port and the illegal flag all change at the clock edge that samples the strobe, and are visible in the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| fieldValid | input | 1 | Length-type field strobe |
| field | input | 12 | Length-type field |
| rdEn | output | 1 | Register read request |
| rdAddr | output | 5 | Register read address |
| rdData | input | XLEN (64) | Register read data, same cycle |
| wrEn | output | 1 | Register write strobe |
| wrAddr | output | 5 | Register write address |
| wrData | output | XLEN (64) | Register write data (new VL) |
| csrWrEn | input | 1 | Direct VL write strobe |
| csrWrData | input | 6 | Direct VL write value, 0 means 64 |
| vl | output | 7 | Current vector length |
| mvl | output | 7 | Maximum vector length |
| illegal | output | 1 | Reserved encoding seen, one cycle |

## Verification
The bench builds the unit with its defaults: a 64-bit register width, a maximum length of 64 and compact registers based at 8. With those values the immediate reaches MVL only up to 32, so lengths from 33 to 64 are reachable only through the control-register port. This makes the zero-means-64 case distinct from every immediate result. The 64-bit read data lets the bench place values with high bits set above the 7-bit length width. Those values show that the minimum is taken over the full register rather than a truncated copy.

// File: rtl/vlset_pkg.sv
package vlset_pkg;

  localparam int REG_AW = 5;
  localparam int IMM_W  = 5;
  localparam int FIELD_W = 12;

  typedef enum logic [2:0] {
    FC_NOP,
    FC_COMPACT,
    FC_FULL_SET,
    FC_FULL_MIN,
    FC_RESERVED
  } fieldClassT;

  typedef struct packed {
    logic              loadMvl;
    logic              vlFromReg;
    logic              vlFromMvl;
    logic              csrLoad;
    logic              wbEn;
    logic [REG_AW-1:0] wbAddr;
    logic [IMM_W-1:0]  imm;
    logic              illegal;
  } vlCtlT;

endpackage

// File: rtl/vlset_ctrl.sv
module vlset_ctrl
  import vlset_pkg::*;
#(
  parameter int CREG_BASE = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               fieldValid,
  input  logic [FIELD_W-1:0] field,
  input  logic               csrWrEn,
  output vlCtlT              ctl,
  output logic               rdEn,
  output logic [REG_AW-1:0]  rdAddr
);

  localparam logic [REG_AW-1:0] BASE = REG_AW'(CREG_BASE);

  fieldClassT fieldClass;

  logic             modeBit;
  logic [IMM_W-1:0] immField;
  logic [2:0]       cSrc;
  logic [2:0]       cDst;
  logic             dirBit;
  logic [4:0]       fullReg;

  assign modeBit  = field[11];
  assign immField = field[10:6];
  assign cDst     = field[5:3];
  assign cSrc     = field[2:0];
  assign dirBit   = field[5];
  assign fullReg  = field[4:0];

  always_comb begin
    if (field == '0)             fieldClass = FC_NOP;
    else if (!modeBit)           fieldClass = FC_COMPACT;
    else if (!dirBit)            fieldClass = FC_FULL_SET;
    else if (fullReg != 5'd0)    fieldClass = FC_FULL_MIN;
    else                         fieldClass = FC_RESERVED;
  end

  always_comb begin
    ctl         = '0;
    rdEn        = 1'b0;
    rdAddr      = '0;
    ctl.imm     = immField;
    if (!fieldValid) begin
      ctl.csrLoad = csrWrEn;
    end else begin
      unique case (fieldClass)
        FC_NOP: begin
        end
        FC_COMPACT: begin
          ctl.loadMvl = 1'b1;
          if (cSrc != 3'd0) begin
            ctl.vlFromReg = 1'b1;
            rdEn          = 1'b1;
            rdAddr        = BASE + REG_AW'(cSrc);
          end else begin
            ctl.vlFromMvl = 1'b1;
          end
          if (cDst != 3'd0) begin
            ctl.wbEn   = 1'b1;
            ctl.wbAddr = BASE + REG_AW'(cDst);
          end
        end
        FC_FULL_SET: begin
          ctl.loadMvl   = 1'b1;
          ctl.vlFromMvl = 1'b1;
          if (fullReg != 5'd0) begin
            ctl.wbEn   = 1'b1;
            ctl.wbAddr = fullReg;
          end
        end
        FC_FULL_MIN: begin
          ctl.loadMvl   = 1'b1;
          ctl.vlFromReg = 1'b1;
          rdEn          = 1'b1;
          rdAddr        = fullReg;
        end
        FC_RESERVED: begin
          ctl.illegal = 1'b1;
        end
        default: begin
        end
      endcase
    end
  end

  // R10: only one source may drive VL in a cycle
  a_r10_one_vl_source: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ctl.vlFromReg, ctl.vlFromMvl, ctl.csrLoad}));

  // R10: a valid field always blocks the direct write
  a_r10_field_blocks_csr: assert property (@(posedge clk) disable iff (!rstN)
    fieldValid |-> !ctl.csrLoad);

  // R2: an all-zero field requests nothing
  a_r2_nop_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (fieldValid && field == '0) |-> (!ctl.loadMvl && !ctl.wbEn && !rdEn && !ctl.illegal));

  // R3: a read is only requested when VL is to be taken from a register
  a_r3_read_only_for_min: assert property (@(posedge clk) disable iff (!rstN)
    rdEn |-> (ctl.vlFromReg && rdAddr != '0));

endmodule

// File: rtl/vlset_dp.sv
module vlset_dp
  import vlset_pkg::*;
#(
  parameter int XLEN    = 64,
  parameter int MAX_LEN = 64,
  parameter int VL_W    = $clog2(MAX_LEN + 1),
  parameter int CSR_W   = $clog2(MAX_LEN)
) (
  input  logic              clk,
  input  logic              rstN,
  input  vlCtlT             ctl,
  input  logic [XLEN-1:0]   rdData,
  input  logic [CSR_W-1:0]  csrWrData,
  output logic              wrEn,
  output logic [REG_AW-1:0] wrAddr,
  output logic [XLEN-1:0]   wrData,
  output logic [VL_W-1:0]   vl,
  output logic [VL_W-1:0]   mvl,
  output logic              illegal
);

  localparam logic [VL_W-1:0] LEN_TOP = VL_W'(MAX_LEN);

  logic [VL_W-1:0] mvlQ, vlQ;
  logic [VL_W-1:0] newMvl;
  logic [VL_W-1:0] regMin;
  logic [VL_W-1:0] csrVal;
  logic [VL_W-1:0] nextVl;
  logic [VL_W-1:0] nextMvl;
  logic [XLEN-1:0] mvlWide;
  logic            wrEnQ;
  logic [REG_AW-1:0] wrAddrQ;
  logic [XLEN-1:0] wrDataQ;
  logic            illegalQ;

  assign newMvl  = VL_W'(ctl.imm) + VL_W'(1);
  assign mvlWide = XLEN'(newMvl);
  assign regMin  = (rdData < mvlWide) ? rdData[VL_W-1:0] : newMvl;
  assign csrVal  = (csrWrData == '0) ? LEN_TOP : VL_W'(csrWrData);

  always_comb begin
    nextMvl = ctl.loadMvl ? newMvl : mvlQ;
    if (ctl.vlFromReg)      nextVl = regMin;
    else if (ctl.vlFromMvl) nextVl = newMvl;
    else if (ctl.csrLoad)   nextVl = csrVal;
    else                    nextVl = vlQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mvlQ     <= LEN_TOP;
      vlQ      <= LEN_TOP;
      wrEnQ    <= 1'b0;
      wrAddrQ  <= '0;
      wrDataQ  <= '0;
      illegalQ <= 1'b0;
    end else begin
      mvlQ     <= nextMvl;
      vlQ      <= nextVl;
      wrEnQ    <= ctl.wbEn;
      wrAddrQ  <= ctl.wbEn ? ctl.wbAddr : '0;
      wrDataQ  <= ctl.wbEn ? XLEN'(nextVl) : '0;
      illegalQ <= ctl.illegal;
    end
  end

  assign vl      = vlQ;
  assign mvl     = mvlQ;
  assign wrEn    = wrEnQ;
  assign wrAddr  = wrAddrQ;
  assign wrData  = wrDataQ;
  assign illegal = illegalQ;

  // R1: MVL stays within 1..MAX_LEN
  a_r1_mvl_in_range: assert property (@(posedge clk) disable iff (!rstN)
    (mvlQ >= VL_W'(1)) && (mvlQ <= LEN_TOP));

  // R4: a length-setting field never leaves VL above MVL
  a_r4_vl_not_above_mvl: assert property (@(posedge clk) disable iff (!rstN)
    ctl.loadMvl |=> (vlQ <= mvlQ));

  // R8: reserved encoding flags and holds state
  a_r8_reserved_holds: assert property (@(posedge clk) disable iff (!rstN)
    ctl.illegal |=> (illegalQ && !wrEnQ && $stable(vlQ) && $stable(mvlQ)));

  // R9: direct write keeps MVL and never yields zero
  a_r9_csr_keeps_mvl: assert property (@(posedge clk) disable iff (!rstN)
    ctl.csrLoad |=> ($stable(mvlQ) && vlQ != '0));

  // R5: written data is the VL now held
  a_r5_write_matches_vl: assert property (@(posedge clk) disable iff (!rstN)
    wrEnQ |-> (wrAddrQ != '0 && wrDataQ == XLEN'(vlQ)));

endmodule

// File: rtl/vl_set_unit.sv
module vl_set_unit
  import vlset_pkg::*;
#(
  parameter int XLEN      = 64,
  parameter int MAX_LEN   = 64,
  parameter int CREG_BASE = 8,
  parameter int VL_W      = $clog2(MAX_LEN + 1),
  parameter int CSR_W     = $clog2(MAX_LEN)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              fieldValid,
  input  logic [11:0]       field,
  output logic              rdEn,
  output logic [4:0]        rdAddr,
  input  logic [XLEN-1:0]   rdData,
  output logic              wrEn,
  output logic [4:0]        wrAddr,
  output logic [XLEN-1:0]   wrData,
  input  logic              csrWrEn,
  input  logic [CSR_W-1:0]  csrWrData,
  output logic [VL_W-1:0]   vl,
  output logic [VL_W-1:0]   mvl,
  output logic              illegal
);

  vlCtlT ctl;

  vlset_ctrl #(
    .CREG_BASE(CREG_BASE)
  ) uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .fieldValid(fieldValid),
    .field     (field),
    .csrWrEn   (csrWrEn),
    .ctl       (ctl),
    .rdEn      (rdEn),
    .rdAddr    (rdAddr)
  );

  vlset_dp #(
    .XLEN   (XLEN),
    .MAX_LEN(MAX_LEN),
    .VL_W   (VL_W),
    .CSR_W  (CSR_W)
  ) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .rdData   (rdData),
    .csrWrData(csrWrData),
    .wrEn     (wrEn),
    .wrAddr   (wrAddr),
    .wrData   (wrData),
    .vl       (vl),
    .mvl      (mvl),
    .illegal  (illegal)
  );

endmodule

// File: tb/tb_vl_set_unit.sv
`timescale 1ns/1ps
module tb_vl_set_unit;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        fieldValid = 1'b0;
  logic [11:0] field = '0;
  logic        rdEn;
  logic [4:0]  rdAddr;
  logic [63:0] rdData;
  logic        wrEn;
  logic [4:0]  wrAddr;
  logic [63:0] wrData;
  logic        csrWrEn = 1'b0;
  logic [5:0]  csrWrData = '0;
  logic [6:0]  vl, mvl;
  logic        illegal;

  logic [63:0] rf [32];
  assign rdData = rf[rdAddr];

  int compared = 0;
  int mismatched = 0;

  typedef struct {
    logic [6:0]  vl;
    logic [6:0]  mvl;
    logic        wrEn;
    logic [4:0]  wrAddr;
    logic [63:0] wrData;
    logic        illegal;
    string       tag;
  } expT;

  expT expQ[$];
  logic [6:0] mVl = 7'd64;
  logic [6:0] mMvl = 7'd64;

  vl_set_unit dut (
    .clk(clk), .rstN(rstN), .fieldValid(fieldValid), .field(field),
    .rdEn(rdEn), .rdAddr(rdAddr), .rdData(rdData),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .csrWrEn(csrWrEn), .csrWrData(csrWrData),
    .vl(vl), .mvl(mvl), .illegal(illegal)
  );

  always #10 clk = ~clk;

  function automatic logic [6:0] minLen(logic [63:0] r, logic [6:0] m);
    return (r < {57'd0, m}) ? r[6:0] : m;
  endfunction

  task automatic finishRun();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  task automatic check1(string tag, logic [63:0] act, logic [63:0] exp, string what);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic pushIdle(string tag);
    expT e;
    e.vl = mVl; e.mvl = mMvl; e.wrEn = 1'b0; e.wrAddr = '0; e.wrData = '0;
    e.illegal = 1'b0; e.tag = tag;
    expQ.push_back(e);
  endtask

  // Model of one field, independent of the RTL
  task automatic applyField(logic [11:0] f, string tag, logic withCsr = 1'b0,
                            logic [5:0] csrV = '0);
    expT e;
    logic        expRd = 1'b0;
    logic [4:0]  expRa = '0;
    logic [6:0]  newM;
    e.wrEn = 1'b0; e.wrAddr = '0; e.wrData = '0; e.illegal = 1'b0; e.tag = tag;
    newM = {2'b0, f[10:6]} + 7'd1;
    if (f == '0) begin
    end else if (!f[11]) begin
      mMvl = newM;
      if (f[2:0] != 0) begin
        expRd = 1'b1; expRa = 5'd8 + {2'b0, f[2:0]};
        mVl = minLen(rf[expRa], newM);
      end else mVl = newM;
      if (f[5:3] != 0) begin
        e.wrEn = 1'b1; e.wrAddr = 5'd8 + {2'b0, f[5:3]}; e.wrData = {57'd0, mVl};
      end
    end else if (!f[5]) begin
      mMvl = newM; mVl = newM;
      if (f[4:0] != 0) begin
        e.wrEn = 1'b1; e.wrAddr = f[4:0]; e.wrData = {57'd0, mVl};
      end
    end else if (f[4:0] != 0) begin
      expRd = 1'b1; expRa = f[4:0];
      mMvl = newM; mVl = minLen(rf[expRa], newM);
    end else begin
      e.illegal = 1'b1;
    end
    e.vl = mVl; e.mvl = mMvl;
    @(negedge clk);
    field = f; fieldValid = 1'b1;
    csrWrEn = withCsr; csrWrData = csrV;
    expQ.push_back(e);
    #1;
    check1({tag, " R3 read port"}, {63'd0, rdEn}, {63'd0, expRd}, "rdEn");
    if (expRd) check1({tag, " R3 read port"}, {59'd0, rdAddr}, {59'd0, expRa}, "rdAddr");
    @(negedge clk);
    fieldValid = 1'b0; field = '0; csrWrEn = 1'b0; csrWrData = '0;
    pushIdle({tag, " idle after"});
  endtask

  task automatic applyCsr(logic [5:0] v, string tag);
    expT e;
    mVl = (v == 0) ? 7'd64 : {1'b0, v};
    e.vl = mVl; e.mvl = mMvl; e.wrEn = 1'b0; e.wrAddr = '0; e.wrData = '0;
    e.illegal = 1'b0; e.tag = tag;
    @(negedge clk);
    csrWrEn = 1'b1; csrWrData = v;
    expQ.push_back(e);
    @(negedge clk);
    csrWrEn = 1'b0; csrWrData = '0;
    pushIdle({tag, " idle after"});
  endtask

  // Monitor: compare each cycle's result after the edge settles
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (expQ.size() > 0) begin
        expT e;
        e = expQ.pop_front();
        compared++;
        if (vl !== e.vl || mvl !== e.mvl || wrEn !== e.wrEn || illegal !== e.illegal ||
            (e.wrEn && (wrAddr !== e.wrAddr || wrData !== e.wrData))) begin
          mismatched++;
          $display("FAIL %s: actual vl=%0d mvl=%0d wr=%0b@%0d:%0h ill=%0b expected vl=%0d mvl=%0d wr=%0b@%0d:%0h ill=%0b",
                   e.tag, vl, mvl, wrEn, wrAddr, wrData, illegal,
                   e.vl, e.mvl, e.wrEn, e.wrAddr, e.wrData, e.illegal);
        end
      end
    end
  end

  initial begin
    #(20 * 100000);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    for (int i = 0; i < 32; i++) rf[i] = 64'(i * 3);
    rf[10] = 64'd20;
    rf[11] = 64'd100;
    rf[12] = 64'd0;
    rf[13] = 64'h8000_0000_0000_0003;
    rf[15] = 64'd7;
    rf[20] = 64'd5;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check1("R1 reset", {57'd0, vl}, 64'd64, "vl");
    check1("R1 reset", {57'd0, mvl}, 64'd64, "mvl");
    check1("R1 reset", {62'd0, wrEn, illegal}, 64'd0, "wrEn/illegal");

    // R6: mode 1 set, imm 15 -> MVL 16, write r3
    applyField({1'b1, 5'd15, 1'b0, 5'd3}, "R6 set with write");
    // R6: mode 1 set, no write, imm 23 -> 24
    applyField({1'b1, 5'd23, 1'b0, 5'd0}, "R6 set without write");
    // R2: all-zero field changes nothing
    applyField(12'd0, "R2 zero field");
    // R3 R4 R5: imm 31, src c2 (r10=20), dst c5 (r13)
    applyField({1'b0, 5'd31, 3'd5, 3'd2}, "R4 R5 min from reg");
    // R4: reg 100 above MVL 32
    applyField({1'b0, 5'd31, 3'd0, 3'd3}, "R4 clamp to MVL");
    // R4: reg 0 gives VL 0
    applyField({1'b0, 5'd31, 3'd1, 3'd4}, "R4 zero length");
    // R4: high bits set above length width
    applyField({1'b0, 5'd9, 3'd0, 3'd5}, "R4 full width compare");
    // R4 R5: no source, no dest, imm 7 -> 8
    applyField({1'b0, 5'd7, 3'd0, 3'd0}, "R4 R5 no regs");
    // R3: compact 7 maps to r15
    applyField({1'b0, 5'd15, 3'd7, 3'd7}, "R3 top compact reg");
    // R7: full reg 20 (=5), imm 9 -> 10
    applyField({1'b1, 5'd9, 1'b1, 5'd20}, "R7 full min");
    // R7: full reg 30 (=90) clamps to 4
    applyField({1'b1, 5'd3, 1'b1, 5'd30}, "R7 full clamp");
    // R8: reserved encoding
    applyField({1'b1, 5'd12, 1'b1, 5'd0}, "R8 reserved");
    // R9: direct write zero means 64, then 17
    applyCsr(6'd0, "R9 csr zero");
    applyCsr(6'd17, "R9 csr value");
    // R10: field and csr together, field wins
    applyField({1'b1, 5'd1, 1'b0, 5'd0}, "R10 field over csr", 1'b1, 6'd40);
    // R10: zero field still blocks csr
    applyField(12'd0, "R10 zero field over csr", 1'b1, 6'd50);
    // R11 timing covered by every monitor comparison
    repeat (4) @(negedge clk);
    check1("R11 queue drained", 64'(expQ.size()), 64'd0, "pending");
    finishRun();
  end

endmodule